// File: doc/BRIEF.md
# Two-Byte Register ALU Processor

A compact 16-bit processor core with eight general-purpose registers. Each instruction is two bytes: an opcode byte, then an operand byte that names a source and a destination register. The core fetches both bytes one at a time from a byte-wide memory with a synchronous read port. The data for an address comes back one clock after the address is driven. The core then runs a single register-to-register ALU operation and writes the result into the destination register.

Each instruction takes exactly three cycles: opcode fetch, operand fetch, then execute. The program counter moves forward by two at the end of execute. There are no loads, stores, branches or interrupts. To build operands, one opcode copies the 4-bit source field into the destination as a small constant. Two sticky flags report an illegal instruction and a division by zero. The whole register file and the program counter are driven out for observation. The reset input is asynchronous and is released on the clock.

Top module: `byte_alu_cpu`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter equals `boot_pc`, all eight registers read zero, and both flags are low.
- R2: Each instruction takes three clock cycles. `mem_addr` is PC in the opcode-fetch cycle and PC+1 in the operand-fetch cycle. PC grows by 2 at the end of the execute cycle, and this holds for every instruction, legal or not.
- R3: Opcode 0x81 sets rD to rD+rS, and opcode 0x82 sets rD to rD−rS. Both wrap modulo 2^16. rS is operand bits [7:4] and rD is operand bits [3:0].
- R4: Opcode 0x83 sets rD to the low 16 bits of rD×rS.
- R5: Opcode 0x84 sets rD to the unsigned quotient rD/rS. When rS is zero, rD keeps its value and `div_zero` goes high and stays high until reset.
- R6: Opcodes 0x85, 0x86 and 0x87 set rD to the bitwise AND, OR and XOR of rD and rS.
- R7: Opcode 0x88 shifts rD right, filling with zeros, by the value held in rS. An amount of 16 or more gives zero.
- R8: Opcode 0x89 shifts rD left by the value held in rS. An amount of 16 or more gives zero.
- R9: Opcode 0x80 loads rD with the operand's upper four bits, zero-extended.
- R10: Any opcode outside 0x80–0x89 leaves all registers unchanged and sets `illegal_op`, which stays high until reset.
- R11: A destination field of 8 or more, or a source field of 8 or more on any opcode other than 0x80, leaves all registers unchanged and sets `illegal_op`.
- R12: An instruction writes no register other than its rD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| boot_pc | input | 16 | PC value loaded by reset |
| mem_addr | output | 16 | Byte address presented to memory |
| mem_rdata | input | 8 | Byte returned one cycle after its address |
| dbg_pc | output | 16 | Current program counter |
| dbg_regs | output | 128 | Register file, register i at bits [16*i+15:16*i] |
| illegal_op | output | 1 | Sticky illegal-instruction flag |
| div_zero | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions assume memory answers with exactly one cycle of latency. They also assume `boot_pc` holds steady while reset is asserted, because the PC stepping and fetch address checks rely on it. The bench models memory as a byte array that registers the address on every rising edge. It sets `boot_pc` once before reset and never changes it. The program runs past its own end into zero bytes, which are illegal opcodes, so the flags and the PC still behave in a defined way after the last checked instruction.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [7:0] {
    OPC_LDI = 8'h80,
    OPC_ADD = 8'h81,
    OPC_SUB = 8'h82,
    OPC_MUL = 8'h83,
    OPC_DIV = 8'h84,
    OPC_AND = 8'h85,
    OPC_OR  = 8'h86,
    OPC_XOR = 8'h87,
    OPC_SHR = 8'h88,
    OPC_SHL = 8'h89
  } opcode_e;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ARG  = 2'd1,
    ST_EXEC = 2'd2
  } phase_e;
endpackage

// File: rtl/byte_alu_unit.sv
module byte_alu_unit
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]         op,
  input  logic [DATA_W-1:0]  dst_val,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [FIELD_W-1:0] imm,
  output logic [DATA_W-1:0]  result,
  output logic               known,
  output logic               by_zero
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SH_LIM = DATA_W'(DATA_W);

  logic sh_big;
  assign sh_big = (src_val >= SH_LIM);

  always_comb begin
    result  = dst_val;
    known   = 1'b1;
    by_zero = 1'b0;
    case (op)
      OPC_LDI: result = DATA_W'(imm);
      OPC_ADD: result = dst_val + src_val;
      OPC_SUB: result = dst_val - src_val;
      OPC_MUL: result = dst_val * src_val;
      OPC_DIV: begin
        if (src_val == '0) by_zero = 1'b1;
        else               result  = dst_val / src_val;
      end
      OPC_AND: result = dst_val & src_val;
      OPC_OR:  result = dst_val | src_val;
      OPC_XOR: result = dst_val ^ src_val;
      OPC_SHR: result = sh_big ? '0 : (dst_val >> src_val[SH_W-1:0]);
      OPC_SHL: result = sh_big ? '0 : (dst_val << src_val[SH_W-1:0]);
      default: known = 1'b0;
    endcase
  end

  // Oversized shift amounts must saturate to zero.
  always_comb begin
    if ((op == OPC_SHR) && sh_big)
      assert_shr_sat_R7: assert (result == '0);
    if ((op == OPC_SHL) && sh_big)
      assert_shl_sat_R8: assert (result == '0);
  end
endmodule

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [DATA_W-1:0]      rd_a,
  output logic [DATA_W-1:0]      rd_b,
  output logic [NREG*DATA_W-1:0] all_regs
);
  localparam int RW = $clog2(NREG);

  logic [NREG-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic reg_en;
    assign reg_en = wr_en && (wr_idx == RW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[i] <= '0;
      else if (reg_en) regs_q[i] <= wr_data;
    end
  end

  assign rd_a     = regs_q[rd_a_idx];
  assign rd_b     = regs_q[rd_b_idx];
  assign all_regs = regs_q;

  // Without a write strobe the whole file must hold.
  assert_hold_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NREG   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   boot_pc,
  input  logic [7:0]          mem_rdata,
  input  logic                alu_known,
  input  logic                alu_by_zero,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ADDR_W-1:0]   pc,
  output logic [7:0]          op,
  output logic [FIELD_W-1:0]  src_fld,
  output logic [FIELD_W-1:0]  dst_fld,
  output logic                wr_en,
  output logic                illegal_op,
  output logic                div_zero
);
  localparam logic [FIELD_W:0] NREG_L = (FIELD_W+1)'(NREG);

  phase_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [7:0]        op_q;
  logic              op_en, pc_en;
  logic              ill_q, ill_d, dz_q, dz_d;
  logic              exec, bad_field, bad;

  assign exec    = (state_q == ST_EXEC);
  assign src_fld = mem_rdata[7:4];
  assign dst_fld = mem_rdata[3:0];
  assign op      = op_q;

  always_comb begin
    bad_field = ({1'b0, dst_fld} >= NREG_L) ||
                ((op_q != OPC_LDI) && ({1'b0, src_fld} >= NREG_L));
    bad       = !alu_known || bad_field;
    wr_en     = exec && !bad && !alu_by_zero;
    ill_d     = ill_q || (exec && bad);
    dz_d      = dz_q || (exec && !bad && alu_by_zero);
    op_en     = (state_q == ST_ARG);
    pc_en     = exec;
    pc_d      = pc_q + ADDR_W'(2);
    case (state_q)
      ST_OPC:  state_d = ST_ARG;
      ST_ARG:  state_d = ST_EXEC;
      default: state_d = ST_OPC;
    endcase
    mem_addr = (state_q == ST_ARG) ? (pc_q + ADDR_W'(1)) : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      pc_q    <= boot_pc;
      op_q    <= '0;
      ill_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
      if (op_en) op_q <= mem_rdata;
      ill_q <= ill_d;
      dz_q  <= dz_d;
    end
  end

  assign pc         = pc_q;
  assign illegal_op = ill_q;
  assign div_zero   = dz_q;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> (pc_q == $past(pc_q) + ADDR_W'(2)));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(pc_q));
  assert_arg_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPC) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  assert_bad_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && bad_field) |-> !wr_en);
  assert_unknown_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !alu_known) |-> (!wr_en ##1 illegal_op));
  assert_dz_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |=> div_zero);
  assert_ill_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> illegal_op);
endmodule

// File: rtl/byte_alu_cpu.sv
module byte_alu_cpu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      boot_pc,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [7:0]             mem_rdata,
  output logic [ADDR_W-1:0]      dbg_pc,
  output logic [NREG*DATA_W-1:0] dbg_regs,
  output logic                   illegal_op,
  output logic                   div_zero
);
  localparam int RW = $clog2(NREG);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [7:0]         op;
  logic [FIELD_W-1:0] src_fld, dst_fld;
  logic               wr_en, alu_known, alu_by_zero;
  logic [DATA_W-1:0]  src_val, dst_val, alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  byte_alu_ctrl #(.ADDR_W(ADDR_W), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .boot_pc(boot_pc), .mem_rdata(mem_rdata),
    .alu_known(alu_known), .alu_by_zero(alu_by_zero), .mem_addr(mem_addr),
    .pc(dbg_pc), .op(op), .src_fld(src_fld), .dst_fld(dst_fld),
    .wr_en(wr_en), .illegal_op(illegal_op), .div_zero(div_zero)
  );

  byte_alu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(dst_fld[RW-1:0]),
    .wr_data(alu_res), .rd_a_idx(src_fld[RW-1:0]), .rd_b_idx(dst_fld[RW-1:0]),
    .rd_a(src_val), .rd_b(dst_val), .all_regs(dbg_regs)
  );

  byte_alu_unit #(.DATA_W(DATA_W)) u_alu (
    .op(op), .dst_val(dst_val), .src_val(src_val), .imm(src_fld),
    .result(alu_res), .known(alu_known), .by_zero(alu_by_zero)
  );

  // Reset state of the observable outputs.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (dbg_regs == '0 && !illegal_op && !div_zero));
endmodule

// File: tb/test_byte_alu_cpu.sv
module test_byte_alu_cpu;
  localparam logic [15:0] BOOT = 16'h0100;

  typedef struct packed {
    logic [15:0]       pc;
    logic [7:0][15:0]  r;
    logic              ill;
    logic              dz;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] boot_pc = BOOT;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] dbg_pc;
  logic [127:0] dbg_regs;
  logic        illegal_op, div_zero;

  logic [7:0]  mem [0:1023];
  exp_t        expq[$];
  string       tagq[$];
  exp_t        model;
  logic [15:0] wptr;
  int          nchk = 0, nfail = 0, issued = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

  byte_alu_cpu i_byte_alu_cpu (
    .clk(clk), .rst_n(rst_n), .boot_pc(boot_pc), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs),
    .illegal_op(illegal_op), .div_zero(div_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: place one instruction and push its expected effect.
  task automatic put(input logic [7:0] opc, input logic [3:0] s, input logic [3:0] d,
                     input string tag);
    logic [15:0] a, b, res;
    logic        ok, wr;
    mem[wptr[9:0]]      = opc;
    mem[wptr[9:0] + 1]  = {s, d};
    wptr = wptr + 16'd2;
    ok = (opc >= 8'h80 && opc <= 8'h89) && (d < 4'd8) && (opc == 8'h80 || s < 4'd8);
    a = model.r[d[2:0]];
    b = model.r[s[2:0]];
    res = a; wr = ok;
    if (ok) begin
      case (opc)
        8'h80: res = {12'd0, s};
        8'h81: res = a + b;
        8'h82: res = a - b;
        8'h83: res = 16'(a * b);
        8'h84: if (b == 0) begin wr = 0; model.dz = 1; end else res = a / b;
        8'h85: res = a & b;
        8'h86: res = a | b;
        8'h87: res = a ^ b;
        8'h88: res = (b >= 16) ? 16'd0 : (a >> b[3:0]);
        default: res = (b >= 16) ? 16'd0 : (a << b[3:0]);
      endcase
    end else model.ill = 1;
    if (wr) model.r[d[2:0]] = res;
    model.pc = model.pc + 16'd2;
    expq.push_back(model);
    tagq.push_back(tag);
    issued++;
  endtask

  // Monitor: pop one expected item on each PC change.
  initial begin : monitor
    exp_t e; string t; logic [15:0] last; int cyc; bit first;
    wait (rst_n === 1'b1);
    last = BOOT; cyc = 0; first = 1;
    while (expq.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (dbg_pc !== last) begin
        e = expq.pop_front(); t = tagq.pop_front();
        check({t, " pc R2"}, {16'd0, dbg_pc}, {16'd0, e.pc});
        check("fetch addr R2", {16'd0, mem_addr}, {16'd0, e.pc});
        if (!first) check("cycles per instr R2", cyc, 3);
        for (int i = 0; i < 8; i++)
          check($sformatf("%s reg%0d R12", t, i), {16'd0, dbg_regs[16*i +: 16]}, {16'd0, e.r[i]});
        check({t, " illegal_op"}, {31'd0, illegal_op}, {31'd0, e.ill});
        check({t, " div_zero"}, {31'd0, div_zero}, {31'd0, e.dz});
        last = dbg_pc; cyc = 0; first = 0;
      end
    end
    done = 1;
  end

  initial begin : main
    int n;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    model = '0; model.pc = BOOT; wptr = BOOT;
    put(8'h80, 4'd5, 4'd0, "ldi r0 R9");
    put(8'h80, 4'd3, 4'd1, "ldi r1 R9");
    put(8'h81, 4'd1, 4'd0, "add R3");
    put(8'h82, 4'd0, 4'd1, "sub wrap R3");
    put(8'h80, 4'd7, 4'd2, "ldi r2 R9");
    put(8'h83, 4'd2, 4'd1, "mul low R4");
    put(8'h80, 4'd12, 4'd3, "ldi r3 R9");
    put(8'h87, 4'd3, 4'd2, "xor R6");
    put(8'h85, 4'd1, 4'd3, "and R6");
    put(8'h86, 4'd0, 4'd3, "or R6");
    put(8'h84, 4'd2, 4'd1, "div R5");
    put(8'h84, 4'd5, 4'd0, "div by zero R5");
    put(8'h80, 4'd8, 4'd4, "ldi r4 R9");
    put(8'h81, 4'd4, 4'd4, "add self R3");
    put(8'h88, 4'd4, 4'd1, "shr 16 R7");
    put(8'h80, 4'd15, 4'd6, "ldi r6 R9");
    put(8'h80, 4'd9, 4'd7, "ldi r7 R9");
    put(8'h89, 4'd6, 4'd7, "shl 15 R8");
    put(8'h88, 4'd6, 4'd7, "shr 15 R7");
    put(8'h80, 4'd3, 4'd5, "ldi r5 R9");
    put(8'h89, 4'd5, 4'd6, "shl 3 R8");
    put(8'h88, 4'd5, 4'd3, "shr 3 R7");
    put(8'h89, 4'd4, 4'd6, "shl 16 R8");
    put(8'h8A, 4'd0, 4'd1, "unknown op R10");
    put(8'h00, 4'd1, 4'd2, "zero op R10");
    put(8'h81, 4'd9, 4'd0, "src field R11");
    put(8'h81, 4'd0, 4'd12, "dst field R11");
    put(8'h80, 4'd3, 4'd8, "ldi dst R11");
    put(8'h83, 4'd3, 4'd3, "mul after flags R4");
    repeat (3) @(negedge clk);
    check("reset pc R1", {16'd0, dbg_pc}, {16'd0, BOOT});
    check("reset regs R1", {31'd0, (dbg_regs == '0)}, 32'd1);
    check("reset flags R1", {30'd0, illegal_op, div_zero}, 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R2: actual %0d results pending expected 0", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule